// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block gathers five interrupt sources, masks them and chooses the one the CPU should vector to next. The sources are two external request pins (active low), two timer overflow events and one serial request. The serial request is the OR of a receive-done flag and a transmit-done flag. Each source has its own enable bit. A global enable bit sits above all five. Each source also has a priority bit that places it at high or low level. Within one level, a fixed polling order picks the winner.

The controller presents a request, the winning source index, its level and its fixed vector address. The CPU answers with an acknowledge strobe when it takes the vector and a return strobe when the handler finishes. Two in-service bits, one per level, record which handlers are running. A high-level request may interrupt a running low-level handler. Nothing interrupts a high-level handler. Each external pin can be set to sense edges or levels. In edge mode a falling edge is latched and then cleared when that source is vectored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The enable byte uses bit 7 as the global enable. Bit 0 enables external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1 and bit 4 serial. Bits 6 and 5 have no effect.
- R2: After reset no request is presented, both in-service bits are 0 and no flag is set.
- R3: Clearing the global enable hides every source. Clearing one source's enable bit hides only that source, and its pending flag is kept.
- R4: The priority byte uses the same bit positions as the enable byte for bits 4..0, where 1 means high level. A pending high-level source wins over every pending low-level source, whatever their polling order.
- R5: Within one level, the winner is the first pending source in this order: external 0 (index 0), timer 0 (1), external 1 (2), timer 1 (3), serial (4).
- R6: The vector is 0x0003 + 8 × index: 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R7: The serial request is the OR of the receive-done and transmit-done inputs. Vectoring does not clear it.
- R8: In edge mode an external flag is set by a falling edge of its pin and cleared when that source is acknowledged. A falling edge in the same cycle as the acknowledge leaves the flag set.
- R9: In level mode an external request equals the inverted pin. It is not latched, so it drops as soon as the pin goes high.
- R10: A timer flag is set by a one-cycle overflow pulse and is cleared when that source is acknowledged.
- R11: An acknowledge while a request is presented sets the in-service bit of the presented level. A return strobe clears the high in-service bit if it is set, and otherwise clears the low one.
- R12: While the low handler is in service, only high-level requests are presented. While the high handler is in service, no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | 8 | Enable byte (bit 7 global, bits 4..0 per source) |
| irq_prio | input | 5 | Priority bits per source, 1 = high level |
| ext_edge | input | 2 | Per external pin: 1 = edge sensing, 0 = level sensing |
| ext_pin_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx_done | input | 1 | Serial receive-done flag |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| cpu_ack | input | 1 | CPU takes the presented vector |
| cpu_reti | input | 1 | CPU returns from the current handler |
| irq_req | output | 1 | A source is presented for vectoring |
| irq_src | output | 3 | Index of the presented source |
| irq_level | output | 1 | Level of the presented source, 1 = high |
| irq_vector | output | 16 | Vector address of the presented source |
| ext_flag | output | 2 | Current request state of each external line |
| in_service | output | 2 | In-service bits (bit 0 low level, bit 1 high level) |

## Verification
Two things can happen in the same cycle, and the bench forces both.

The first is a new falling edge on an edge-mode pin arriving in the cycle its pending flag is acknowledged. The bench raises the pin and holds it high, then drops it in the cycle it asserts the acknowledge. It then checks that the flag is still set and that the source is presented again after the return strobe.

The second is a high-level request arriving while a low handler runs. The bench checks that it is presented at once, that both in-service bits are set after it is acknowledged, and that the return strobes unwind the high level first and the low level second.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC       = 5;
  localparam int SRC_W      = $clog2(NSRC);
  localparam int NEXT       = 2;
  localparam int NTMR       = 2;
  localparam int VEC_W      = 16;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int GLOBAL_BIT = 7;

  // source indices, also the polling order
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;

  typedef logic [NSRC-1:0] src_vec_t;

  function automatic logic [VEC_W-1:0] vec_addr(input logic [SRC_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STRIDE * int'(idx));
  endfunction

  // lowest set index wins
  function automatic logic [SRC_W-1:0] poll_pick(input src_vec_t v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = SRC_W'(i);
    end
    return r;
  endfunction

  function automatic src_vec_t onehot_of(input logic [SRC_W-1:0] idx);
    src_vec_t r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (SRC_W'(i) == idx) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_ext_sense.sv
module irqc_ext_sense #(
  parameter int NLINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] pin_n,
  input  logic [NLINE-1:0] mode_edge,
  input  logic [NLINE-1:0] clr,
  output logic [NLINE-1:0] req,
  output logic [NLINE-1:0] fall
);
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic pin_prev;
    logic edge_flag;

    assign fall[g] = pin_prev & ~pin_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_prev  <= 1'b1;
        edge_flag <= 1'b0;
      end else begin
        pin_prev <= pin_n[g];
        if (!mode_edge[g])
          edge_flag <= 1'b0;
        else if (fall[g])
          edge_flag <= 1'b1;
        else if (clr[g])
          edge_flag <= 1'b0;
      end
    end

    assign req[g] = mode_edge[g] ? edge_flag : ~pin_n[g];
  end
endmodule

// File: rtl/irqc_tmr_flags.sv
module irqc_tmr_flags #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] ovf,
  input  logic [NT-1:0] clr,
  output logic [NT-1:0] flag
);
  for (genvar g = 0; g < NT; g++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag[g] <= 1'b0;
      else if (ovf[g])
        flag[g] <= 1'b1;
      else if (clr[g])
        flag[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select
  import irqc_pkg::*;
(
  input  src_vec_t         req,
  input  src_vec_t         prio,
  input  logic [1:0]       isr,
  output logic             valid,
  output logic [SRC_W-1:0] idx,
  output logic             level
);
  src_vec_t hi_req;
  src_vec_t lo_req;

  assign hi_req = req & prio;
  assign lo_req = req & ~prio;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    level = 1'b0;
    if (!isr[1]) begin
      if (|hi_req) begin
        valid = 1'b1;
        idx   = poll_pick(hi_req);
        level = 1'b1;
      end else if (!isr[0] && |lo_req) begin
        valid = 1'b1;
        idx   = poll_pick(lo_req);
      end
    end
  end
endmodule

// File: rtl/irqc_inservice.sv
module irqc_inservice (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_level,
  input  logic       reti,
  output logic [1:0] isr
);
  logic [1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr;
    if (reti) begin
      if (isr[1]) isr_nxt[1] = 1'b0;
      else        isr_nxt[0] = 1'b0;
    end
    if (take) isr_nxt[take_level] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= 2'b00;
    else        isr <= isr_nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       irq_en,
  input  logic [NSRC-1:0]  irq_prio,
  input  logic [NEXT-1:0]  ext_edge,
  input  logic [NEXT-1:0]  ext_pin_n,
  input  logic [NTMR-1:0]  tmr_ovf,
  input  logic             ser_rx_done,
  input  logic             ser_tx_done,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             irq_req,
  output logic [SRC_W-1:0] irq_src,
  output logic             irq_level,
  output logic [VEC_W-1:0] irq_vector,
  output logic [NEXT-1:0]  ext_flag,
  output logic [1:0]       in_service
);
  // named internal events
  logic            take;
  src_vec_t        take_vec;
  logic [NEXT-1:0] ext_fall;
  logic [NTMR-1:0] tmr_flag;
  src_vec_t        raw_req;
  src_vec_t        masked_req;

  assign take     = cpu_ack & irq_req;
  assign take_vec = take ? onehot_of(irq_src) : '0;

  irqc_ext_sense #(.NLINE(NEXT)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (ext_pin_n),
    .mode_edge (ext_edge),
    .clr       ({take_vec[SRC_EXT1], take_vec[SRC_EXT0]}),
    .req       (ext_flag),
    .fall      (ext_fall)
  );

  irqc_tmr_flags #(.NT(NTMR)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .ovf   (tmr_ovf),
    .clr   ({take_vec[SRC_TMR1], take_vec[SRC_TMR0]}),
    .flag  (tmr_flag)
  );

  always_comb begin
    raw_req           = '0;
    raw_req[SRC_EXT0] = ext_flag[0];
    raw_req[SRC_TMR0] = tmr_flag[0];
    raw_req[SRC_EXT1] = ext_flag[1];
    raw_req[SRC_TMR1] = tmr_flag[1];
    raw_req[SRC_SER]  = ser_rx_done | ser_tx_done;
  end

  assign masked_req = raw_req & irq_en[NSRC-1:0] & {NSRC{irq_en[GLOBAL_BIT]}};

  irqc_select u_sel (
    .req   (masked_req),
    .prio  (irq_prio),
    .isr   (in_service),
    .valid (irq_req),
    .idx   (irq_src),
    .level (irq_level)
  );

  assign irq_vector = vec_addr(irq_src);

  irqc_inservice u_isr (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_level (irq_level),
    .reti       (cpu_reti),
    .isr        (in_service)
  );
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  irq_en,
  input logic [1:0]  ext_edge,
  input logic        cpu_ack,
  input logic        irq_req,
  input logic [2:0]  irq_src,
  input logic        irq_level,
  input logic [15:0] irq_vector,
  input logic [1:0]  ext_flag,
  input logic [1:0]  ext_fall,
  input logic [1:0]  in_service
);
  AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en[7] |-> !irq_req); // R3
  AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[1] |-> !irq_req); // R12
  AST_LOW_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service[0] && irq_req) |-> irq_level); // R12
  AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector[15:6] == 10'd0)); // R6
  AST_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req && irq_level) |=> in_service[1]); // R11
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req && !irq_level) |=> in_service[0]); // R11
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && irq_req && irq_src == 3'd0 && ext_edge[0] && !ext_fall[0])
      |=> (!ext_flag[0] || !ext_edge[0])); // R8
  AST_EDGE_SETWINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge[1] && ext_fall[1]) |=> (ext_flag[1] || !ext_edge[1])); // R8
endmodule

bind prio_irq_ctrl irqc_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_en     (irq_en),
  .ext_edge   (ext_edge),
  .cpu_ack    (cpu_ack),
  .irq_req    (irq_req),
  .irq_src    (irq_src),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .ext_flag   (ext_flag),
  .ext_fall   (ext_fall),
  .in_service (in_service)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_en = '0;
  logic [4:0]  irq_prio = '0;
  logic [1:0]  ext_edge = '0;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_rx_done = 1'b0;
  logic        ser_tx_done = 1'b0;
  logic        cpu_ack = 1'b0;
  logic        cpu_reti = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_src;
  logic        irq_level;
  logic [15:0] irq_vector;
  logic [1:0]  ext_flag;
  logic [1:0]  in_service;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_prio(irq_prio),
    .ext_edge(ext_edge), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
    .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_req(irq_req),
    .irq_src(irq_src), .irq_level(irq_level), .irq_vector(irq_vector),
    .ext_flag(ext_flag), .in_service(in_service)
  );

  function automatic logic [15:0] exp_vec(input int idx);
    return 16'(3 + idx * 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_src(input string req, input int idx, input logic lvl);
    check(req, 32'(irq_req), 32'd1);
    check(req, 32'(irq_src), 32'(idx));
    check(req, 32'(irq_level), 32'(lvl));
    check(req, 32'(irq_vector), 32'(exp_vec(idx)));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_ack();
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
  endtask

  task automatic do_reti();
    cpu_reti = 1'b1; step(); cpu_reti = 1'b0;
  endtask

  task automatic pulse_tmr(input logic [1:0] which);
    tmr_ovf = which; step(); tmr_ovf = 2'b00;
  endtask

  task automatic t_reset();
    check("R2 req", 32'(irq_req), 32'd0);
    check("R2 isr", 32'(in_service), 32'd0);
    check("R2 flags", 32'(ext_flag), 32'd0);
    pulse_tmr(2'b01);
    check("R2 masked after reset", 32'(irq_req), 32'd0);
  endtask

  task automatic t_masks();
    irq_en = 8'h02; step();
    check("R3 global off", 32'(irq_req), 32'd0);
    irq_en = 8'h62; step();
    check("R1 reserved bits not global", 32'(irq_req), 32'd0);
    irq_en = 8'h82; step();
    expect_src("R1 timer0 enable bit1", 1, 1'b0);
    irq_en = 8'hFD; step();
    check("R3 single mask", 32'(irq_req), 32'd0);
    irq_en = 8'h82; step();
    expect_src("R3 flag kept while masked", 1, 1'b0);
    do_ack(); do_reti();
    check("R10 timer flag cleared", 32'(irq_req), 32'd0);
  endtask

  task automatic t_polling();
    irq_en = 8'h9F; irq_prio = 5'h00;
    ser_rx_done = 1'b1; tmr_ovf = 2'b11; step(); tmr_ovf = 2'b00;
    expect_src("R5 timer0 first", 1, 1'b0);
    do_ack();
    check("R11 low isr set", 32'(in_service), 32'd1);
    check("R12 low blocks low", 32'(irq_req), 32'd0);
    do_reti();
    check("R11 reti clears low", 32'(in_service), 32'd0);
    expect_src("R5 timer1 next", 3, 1'b0);
    do_ack(); do_reti();
    expect_src("R6 serial vector", 4, 1'b0);
    do_ack(); do_reti();
    expect_src("R7 serial not cleared by ack", 4, 1'b0);
    ser_rx_done = 1'b0; ser_tx_done = 1'b1; step();
    expect_src("R7 tx side", 4, 1'b0);
    ser_tx_done = 1'b0; step();
    check("R7 serial drop", 32'(irq_req), 32'd0);
  endtask

  task automatic t_priority();
    irq_en = 8'h9F; irq_prio = 5'h10;
    pulse_tmr(2'b01);
    expect_src("R4 low timer0", 1, 1'b0);
    do_ack();
    ser_tx_done = 1'b1; step();
    expect_src("R12 high preempts low", 4, 1'b1);
    do_ack();
    check("R11 both isr", 32'(in_service), 32'd3);
    pulse_tmr(2'b10);
    check("R12 high blocks all", 32'(irq_req), 32'd0);
    do_reti();
    check("R11 reti clears high first", 32'(in_service), 32'd1);
    expect_src("R12 high still shown", 4, 1'b1);
    ser_tx_done = 1'b0; step();
    check("R12 low waits", 32'(irq_req), 32'd0);
    do_reti();
    expect_src("R5 timer1 after unwind", 3, 1'b0);
    ser_tx_done = 1'b1; step();
    expect_src("R4 high beats earlier low", 4, 1'b1);
    ser_tx_done = 1'b0; step();
    do_ack(); do_reti();
    check("R10 clean", 32'(irq_req), 32'd0);
    irq_prio = 5'h00;
  endtask

  task automatic t_edge();
    irq_en = 8'h81; ext_edge = 2'b01;
    ext_pin_n[0] = 1'b0; step();
    expect_src("R8 edge latched", 0, 1'b0);
    do_ack();
    check("R8 flag cleared by ack", 32'(ext_flag[0]), 32'd0);
    do_reti();
    check("R8 held low pin no request", 32'(irq_req), 32'd0);
    ext_pin_n[0] = 1'b1; step();
    ext_pin_n[0] = 1'b0; step();
    ext_pin_n[0] = 1'b1; step();
    check("R8 flag kept after pin rise", 32'(ext_flag[0]), 32'd1);
    ext_pin_n[0] = 1'b0; cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    check("R8 new edge wins over ack", 32'(ext_flag[0]), 32'd1);
    check("R11 isr on ack", 32'(in_service), 32'd1);
    do_reti();
    expect_src("R8 presented again", 0, 1'b0);
    do_ack(); do_reti();
    check("R8 cleared", 32'(irq_req), 32'd0);
    ext_pin_n[0] = 1'b1; step();
  endtask

  task automatic t_level();
    irq_en = 8'h84; ext_edge = 2'b00;
    ext_pin_n[1] = 1'b0; step();
    expect_src("R9 level ext1", 2, 1'b0);
    do_ack(); do_reti();
    expect_src("R9 still low pin", 2, 1'b0);
    ext_pin_n[1] = 1'b1; step();
    check("R9 no latch", 32'(irq_req), 32'd0);
    check("R9 flag follows pin", 32'(ext_flag[1]), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_masks();
    t_polling();
    t_priority();
    t_edge();
    t_level();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule